// File: doc/BRIEF.md
# Isolated I/O Port Bridge

This block sits between a small processor bus and a handful of byte-wide I/O ports. The bus keeps memory and I/O in separate address spaces. The block turns the shared read strobe, the shared write strobe and an I/O-cycle flag into its own active-low I/O read and I/O write commands. It fully decodes a 16-bit port address, so it serves both the short form (upper address byte zero, ports 00h–FFh) and the long form (the full 16-bit address).

On the 16-bit data bus, even addresses use the low byte lane and odd addresses use the high byte lane. A high-bank enable marks the high lane as active. Two output ports at an even/odd pair hold whatever was last written to them, because write data is on the bus only briefly. Two input ports at another even/odd pair are read together, so one 16-bit read returns both. A block of four consecutive byte registers can be written and read back.

When no input source is selected, the read bus is released. This is shown as an enable flag, with the data forced to zero. All ports are plain control pins with no valid/ready handshake. An access completes in the cycle its strobe is sampled, so the block never applies back-pressure.

Top module: `io_port_bridge`

## Requirements
- R1: `iorc_n` is low exactly when `rd_n` is low and `io_cyc` is 1, and `iowc_n` is low exactly when `wr_n` is low and `io_cyc` is 1. Neither is ever low while `io_cyc` is 0 (memory cycle).
- R2: An I/O write at address `OUT_BASE` (default 0040h, A0=0) loads `wdata[7:0]` into `port_even` at the clock edge where the write is sampled.
- R3: An I/O write at `OUT_BASE+1` (A0=1) with `bhe_n`=0 loads `wdata[15:8]` into `port_odd`. With `bhe_n`=1 the odd port keeps its value.
- R4: A 16-bit I/O write at `OUT_BASE` with `bhe_n`=0 loads both ports in the same edge: low lane to `port_even`, high lane to `port_odd`.
- R5: The output ports keep their values when strobes are idle, and during memory writes to the same address.
- R6: An I/O read at `IN_BASE` or `IN_BASE+1` (default 0064h/0065h, A0 ignored) drives `rdata = {in_hi, in_lo}` with `rdata_oe`=1, in the same cycle.
- R7: When no input source is selected, or `iorc_n` is high, `rdata_oe` is 0 and `rdata` is 0.
- R8: All 16 address bits beyond the ignored low bits are decoded. Addresses such as 1040h or 1064h reach no port.
- R9: Addresses `BLK_BASE`..`BLK_BASE+3` (default 0700h–0703h) select byte register A1..A0, in I/O cycles only. A0=0 uses the low lane; A0=1 uses the high lane and needs `bhe_n`=0. Register i sits at `blk_q[8i+7:8i]`. A read returns the register on its lane, with the other lane zero.
- R10: A synchronous reset (`rst`=1) clears `port_even`, `port_odd` and all of `blk_q` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_n | input | 1 | Bus read strobe, active low |
| wr_n | input | 1 | Bus write strobe, active low |
| io_cyc | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| addr | input | 16 | Port address |
| bhe_n | input | 1 | High byte lane enable, active low |
| wdata | input | 16 | Write data bus |
| in_lo | input | 8 | Even input port source |
| in_hi | input | 8 | Odd input port source |
| iorc_n | output | 1 | I/O read command, active low |
| iowc_n | output | 1 | I/O write command, active low |
| port_even | output | 8 | Even output port latch |
| port_odd | output | 8 | Odd output port latch |
| blk_q | output | 32 | Four block registers, register i at bits 8i+7..8i |
| rdata | output | 16 | Read data toward the bus |
| rdata_oe | output | 1 | Read bus drive enable |

## Verification
The assertions check these rules on every cycle:
- no command is raised during a memory cycle;
- an even-port write lands on the next edge;
- the odd port holds while its lane is idle;
- the read bus is driven only under an I/O read;
- block registers hold through memory cycles.

Only the bench scenarios can show the remaining behaviour: that decoding is exact (near-miss and aliased addresses are rejected), the byte-lane steering on 16-bit and odd-byte accesses, the paired input read with A0 ignored, and that reset clears state in the middle of a run.

// File: rtl/io_pkg.sv
package io_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 2 * BYTE_W;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/io_cmd_gen.sv
module io_cmd_gen (
  input  logic rd_n,
  input  logic wr_n,
  input  logic io_cyc,
  output logic iorc_n,
  output logic iowc_n
);
  assign iorc_n = ~(io_cyc & ~rd_n);
  assign iowc_n = ~(io_cyc & ~wr_n);
endmodule

// File: rtl/io_addr_dec.sv
module io_addr_dec #(
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = '0,
  parameter int IGN = 0
) (
  input  logic [AW-1:0] addr,
  input  logic          en_n,
  output logic          sel_n
);
  logic hit;
  assign hit   = (addr[AW-1:IGN] == BASE[AW-1:IGN]);
  assign sel_n = ~(~en_n & hit);
endmodule

// File: rtl/io_byte_latch.sv
module io_byte_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (we) q <= d;
  end
endmodule

// File: rtl/io_port_bridge.sv
module io_port_bridge
  import io_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OUT_BASE = 16'h0040,
  parameter logic [ADDR_W-1:0] IN_BASE  = 16'h0064,
  parameter logic [ADDR_W-1:0] BLK_BASE = 16'h0700,
  parameter int BLK_SEL_W = 2,
  localparam int BLK_N = 1 << BLK_SEL_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_n,
  input  logic                    wr_n,
  input  logic                    io_cyc,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    bhe_n,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [BYTE_W-1:0]       in_lo,
  input  logic [BYTE_W-1:0]       in_hi,
  output logic                    iorc_n,
  output logic                    iowc_n,
  output logic [BYTE_W-1:0]       port_even,
  output logic [BYTE_W-1:0]       port_odd,
  output logic [BLK_N*BYTE_W-1:0] blk_q,
  output logic [DATA_W-1:0]       rdata,
  output logic                    rdata_oe
);
  logic out_sel_n, in_sel_n, blk_sel_n, any_cmd_n;
  logic even_we, odd_we;
  byte_t lane_byte;
  byte_t blk_r [BLK_N];

  io_cmd_gen u_cmd (
    .rd_n(rd_n), .wr_n(wr_n), .io_cyc(io_cyc),
    .iorc_n(iorc_n), .iowc_n(iowc_n)
  );

  assign any_cmd_n = iorc_n & iowc_n;

  // Output pair decode ignores A0; lanes gate each byte.
  io_addr_dec #(.AW(ADDR_W), .BASE(OUT_BASE), .IGN(1)) u_dec_out (
    .addr(addr), .en_n(iowc_n), .sel_n(out_sel_n)
  );
  io_addr_dec #(.AW(ADDR_W), .BASE(IN_BASE), .IGN(1)) u_dec_in (
    .addr(addr), .en_n(iorc_n), .sel_n(in_sel_n)
  );
  io_addr_dec #(.AW(ADDR_W), .BASE(BLK_BASE), .IGN(BLK_SEL_W)) u_dec_blk (
    .addr(addr), .en_n(any_cmd_n), .sel_n(blk_sel_n)
  );

  assign even_we   = ~out_sel_n & ~addr[0];
  assign odd_we    = ~out_sel_n & ~bhe_n;
  assign lane_byte = addr[0] ? wdata[DATA_W-1:BYTE_W] : wdata[BYTE_W-1:0];

  io_byte_latch #(.W(BYTE_W)) u_even (
    .clk(clk), .rst(rst), .we(even_we), .d(wdata[BYTE_W-1:0]), .q(port_even)
  );
  io_byte_latch #(.W(BYTE_W)) u_odd (
    .clk(clk), .rst(rst), .we(odd_we), .d(wdata[DATA_W-1:BYTE_W]), .q(port_odd)
  );

  for (genvar g = 0; g < BLK_N; g++) begin : g_blk
    logic reg_we;
    assign reg_we = ~blk_sel_n & ~iowc_n
                  & (addr[BLK_SEL_W-1:0] == BLK_SEL_W'(g))
                  & (addr[0] ? ~bhe_n : 1'b1);
    io_byte_latch #(.W(BYTE_W)) u_reg (
      .clk(clk), .rst(rst), .we(reg_we), .d(lane_byte), .q(blk_r[g])
    );
    assign blk_q[g*BYTE_W +: BYTE_W] = blk_r[g];
  end

  always_comb begin
    rdata    = '0;
    rdata_oe = 1'b0;
    if (!in_sel_n) begin
      rdata    = {in_hi, in_lo};
      rdata_oe = 1'b1;
    end else if (!blk_sel_n && !iorc_n) begin
      rdata_oe = 1'b1;
      if (addr[0]) rdata[DATA_W-1:BYTE_W] = blk_r[addr[BLK_SEL_W-1:0]];
      else         rdata[BYTE_W-1:0]      = blk_r[addr[BLK_SEL_W-1:0]];
    end
  end

  assert_no_mem_cmd_R1: assert property (@(posedge clk) disable iff (rst)
    !io_cyc |-> (iorc_n && iowc_n));
  assert_even_load_R2: assert property (@(posedge clk) disable iff (rst)
    (!iowc_n && addr == OUT_BASE) |=> (port_even == $past(wdata[BYTE_W-1:0])));
  assert_odd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (bhe_n || iowc_n) |=> $stable(port_odd));
  assert_oe_needs_read_R7: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> !iorc_n);
  assert_blk_io_only_R9: assert property (@(posedge clk) disable iff (rst)
    !io_cyc |=> $stable(blk_q));
endmodule

// File: tb/io_port_bridge_bench.sv
module io_port_bridge_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_n = 1'b1, wr_n = 1'b1, io_cyc = 1'b1, bhe_n = 1'b1;
  logic [15:0] addr = '0, wdata = '0;
  logic [7:0] in_lo = '0, in_hi = '0;
  logic iorc_n, iowc_n, rdata_oe;
  logic [7:0] port_even, port_odd;
  logic [31:0] blk_q;
  logic [15:0] rdata;

  typedef struct { int req; int kind; logic [31:0] exp; } exp_t;
  exp_t sb[$];
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  io_port_bridge u_io_port_bridge (
    .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n), .io_cyc(io_cyc),
    .addr(addr), .bhe_n(bhe_n), .wdata(wdata), .in_lo(in_lo), .in_hi(in_hi),
    .iorc_n(iorc_n), .iowc_n(iowc_n), .port_even(port_even), .port_odd(port_odd),
    .blk_q(blk_q), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  function automatic void expect_val(int req, int kind, logic [31:0] v);
    exp_t e;
    e.req = req; e.kind = kind; e.exp = v;
    sb.push_back(e);
  endfunction

  // kinds: 0 port_even, 1 port_odd, 2 blk_q, 3 rdata, 4 rdata_oe, 5 {iorc_n,iowc_n}
  initial forever begin
    @(posedge clk); #5;
    while (sb.size() > 0) begin
      exp_t e;
      logic [31:0] act;
      e = sb.pop_front();
      case (e.kind)
        0: act = {24'h0, port_even};
        1: act = {24'h0, port_odd};
        2: act = blk_q;
        3: act = {16'h0, rdata};
        4: act = {31'h0, rdata_oe};
        default: act = {30'h0, iorc_n, iowc_n};
      endcase
      total++;
      if (act !== e.exp) begin
        bad++;
        $display("FAIL R%0d kind=%0d actual=%h expected=%h", e.req, e.kind, act, e.exp);
      end
    end
  end

  task automatic access(input logic rd, input logic wr, input logic io,
                        input logic [15:0] a, input logic bhe, input logic [15:0] d);
    @(negedge clk);
    rd_n = ~rd; wr_n = ~wr; io_cyc = io; addr = a; bhe_n = bhe; wdata = d;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    access(1'b0, 1'b0, 1'b1, 16'h0000, 1'b1, 16'h0000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    idle();
    // R10 reset state
    expect_val(10, 0, 0); expect_val(10, 1, 0); expect_val(10, 2, 0);
    expect_val(7, 4, 0);
    // R1 memory read/write raise no command; R5 memory write leaves port
    access(1'b1, 1'b0, 1'b0, 16'h0064, 1'b0, 16'h0000);
    expect_val(1, 5, 32'h3); expect_val(7, 4, 0);
    access(1'b0, 1'b1, 1'b0, 16'h0040, 1'b0, 16'h55AA);
    expect_val(1, 5, 32'h3); expect_val(5, 0, 0);
    access(1'b1, 1'b0, 1'b1, 16'h0010, 1'b1, 16'h0000);
    expect_val(1, 5, 32'h1);
    access(1'b0, 1'b1, 1'b1, 16'h0010, 1'b1, 16'h0000);
    expect_val(1, 5, 32'h2);
    // R2 even byte write
    access(1'b0, 1'b1, 1'b1, 16'h0040, 1'b1, 16'h1234);
    expect_val(2, 0, 32'h34); expect_val(2, 1, 0);
    // R3 odd byte write, then lane disabled
    access(1'b0, 1'b1, 1'b1, 16'h0041, 1'b0, 16'hAB00);
    expect_val(3, 1, 32'hAB); expect_val(3, 0, 32'h34);
    access(1'b0, 1'b1, 1'b1, 16'h0041, 1'b1, 16'hCD00);
    expect_val(3, 1, 32'hAB);
    // R4 word write
    access(1'b0, 1'b1, 1'b1, 16'h0040, 1'b0, 16'hBEEF);
    expect_val(4, 0, 32'hEF); expect_val(4, 1, 32'hBE);
    // R5 persistence
    idle(); idle();
    expect_val(5, 0, 32'hEF); expect_val(5, 1, 32'hBE);
    // R8 aliases rejected
    access(1'b0, 1'b1, 1'b1, 16'h1040, 1'b0, 16'h0101);
    expect_val(8, 0, 32'hEF); expect_val(8, 1, 32'hBE);
    access(1'b0, 1'b1, 1'b1, 16'h0042, 1'b0, 16'h0202);
    expect_val(8, 0, 32'hEF); expect_val(8, 1, 32'hBE);
    in_lo = 8'h5A; in_hi = 8'hC3;
    access(1'b1, 1'b0, 1'b1, 16'h1064, 1'b0, 16'h0000);
    expect_val(8, 4, 0);
    // R6 paired input read, A0 ignored
    access(1'b1, 1'b0, 1'b1, 16'h0064, 1'b0, 16'h0000);
    expect_val(6, 3, 32'hC35A); expect_val(6, 4, 1);
    access(1'b1, 1'b0, 1'b1, 16'h0065, 1'b0, 16'h0000);
    expect_val(6, 3, 32'hC35A); expect_val(6, 4, 1);
    // R7 unselected read and address without strobe
    access(1'b1, 1'b0, 1'b1, 16'h0066, 1'b0, 16'h0000);
    expect_val(7, 4, 0); expect_val(7, 3, 0);
    access(1'b0, 1'b0, 1'b1, 16'h0064, 1'b0, 16'h0000);
    expect_val(7, 4, 0); expect_val(7, 3, 0);
    // R9 register block
    access(1'b0, 1'b1, 1'b1, 16'h0700, 1'b1, 16'h0011);
    access(1'b0, 1'b1, 1'b1, 16'h0701, 1'b0, 16'h2200);
    access(1'b0, 1'b1, 1'b1, 16'h0702, 1'b1, 16'h0033);
    access(1'b0, 1'b1, 1'b1, 16'h0703, 1'b0, 16'h4400);
    expect_val(9, 2, 32'h44332211);
    access(1'b0, 1'b1, 1'b1, 16'h0701, 1'b1, 16'h9900);
    expect_val(9, 2, 32'h44332211);
    access(1'b1, 1'b0, 1'b1, 16'h0702, 1'b0, 16'h0000);
    expect_val(9, 3, 32'h0033); expect_val(9, 4, 1);
    access(1'b1, 1'b0, 1'b1, 16'h0703, 1'b0, 16'h0000);
    expect_val(9, 3, 32'h4400);
    access(1'b0, 1'b1, 1'b0, 16'h0700, 1'b0, 16'h00FF);
    expect_val(9, 2, 32'h44332211);
    access(1'b0, 1'b1, 1'b1, 16'h0704, 1'b0, 16'hFFFF);
    expect_val(8, 2, 32'h44332211);
    // R10 reset mid-run
    @(negedge clk); rd_n = 1'b1; wr_n = 1'b1; rst = 1'b1;
    @(posedge clk); #1;
    expect_val(10, 0, 0); expect_val(10, 1, 0); expect_val(10, 2, 0);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule